// File: doc/BRIEF.md
# Bit-Sliced Ripple Arithmetic/Logic Unit

This block is a combinational arithmetic/logic unit built from a chain of identical one-bit slices. Each slice takes one bit of each operand, a carry-in and the shared 3-bit operation code. It returns one result bit and a carry-out. The carry-out of each slice drives the carry-in of the slice above it. The carry-out of the top slice becomes the unit's carry output.

Inside a slice, a four-way selector steered by the two low opcode bits chooses one of four values: the AND of the operand bits, their OR, the full-adder sum, or a constant zero. Opcode bit 2 inverts the slice's b input and is also the carry into the bottom slice. With that bit set, the add code performs two's-complement subtraction. There is no clock and no reset. The slice is a module of its own so that it can be checked on its own.

Top module: `alu_ripple32`

## Requirements
- R1: Opcode 3'b000 makes result equal to the bitwise AND of a and b, with carry_out 0.
- R2: Opcode 3'b001 makes result equal to the bitwise OR of a and b, with carry_out 0.
- R3: Opcode 3'b010 makes {carry_out, result} equal to the WIDTH+1-bit sum a + b.
- R4: Opcode 3'b110 makes result equal to a - b modulo 2^WIDTH. In this case carry_out is the carry out of a + ~b + 1, which is 1 exactly when a >= b unsigned.
- R5: Opcodes 3'b011, 3'b100, 3'b101 and 3'b111 give result 0 and carry_out 0, in both the slice and the full unit.
- R6: In the one-bit slice, the bit order is op[2:0], then a, then b, then cin. The slice's result is a&b for opcode 000 and a|b for opcode 001. For opcodes 010 and 110 it is a ^ b' ^ cin, where b' is b inverted when op[2] is 1.
- R7: The slice's carry-out is the majority of a, b' and cin for opcodes 010 and 110, and 0 for every other opcode.
- R8: Carries ripple from bit 0 to bit WIDTH-1, and bit 0 receives op[2] as its carry-in. As a result, a carry produced in bit 0 travels through the whole chain, for example all-ones plus one gives result 0 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 3 | Operation code |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected logic or arithmetic result |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The bench builds the full unit with the default WIDTH of 32 and also builds a standalone one-bit slice. The slice's six inputs span only 64 combinations, so every one of them is driven against the table above. At 32 bits, the bench drives the operand patterns that force the carry to ripple through all 32 slices: all-ones plus one, and zero minus one. It also drives random operands for every defined and undefined opcode.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam logic [2:0] OPC_AND = 3'b000;
    localparam logic [2:0] OPC_OR  = 3'b001;
    localparam logic [2:0] OPC_ADD = 3'b010;
    localparam logic [2:0] OPC_SUB = 3'b110;

    // Index into the four-way selector inside a slice
    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_ZERO = 2'd3
    } pick_e;

    typedef struct packed {
        pick_e pick;
        logic  inv_b;
        logic  arith;
    } op_ctl_t;

    typedef struct packed {
        logic res;
        logic co;
    } slice_out_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [2:0] op,
    output op_ctl_t    ctl
);

    op_ctl_t ctl_d;

    always_comb begin
        ctl_d = '{pick: PICK_ZERO, inv_b: 1'b0, arith: 1'b0};
        unique case (op)
            OPC_AND: ctl_d.pick = PICK_AND;
            OPC_OR:  ctl_d.pick = PICK_OR;
            OPC_ADD: begin
                ctl_d.pick  = PICK_SUM;
                ctl_d.arith = 1'b1;
            end
            OPC_SUB: begin
                ctl_d.pick  = PICK_SUM;
                ctl_d.inv_b = 1'b1;
                ctl_d.arith = 1'b1;
            end
            default: ctl_d.pick = PICK_ZERO;
        endcase
    end

    assign ctl = ctl_d;

    // A code outside the four defined ones must select the zero path
    always_comb begin
        if (!(op == OPC_AND || op == OPC_OR || op == OPC_ADD || op == OPC_SUB))
            AST_UNDEF_PICKS_ZERO: assert (ctl.pick == PICK_ZERO && !ctl.arith); // R5
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic [2:0] op,
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    output logic       res,
    output logic       cout
);

    op_ctl_t    ctl;
    slice_out_t out_d;
    logic       b_eff;
    logic       fa_sum;
    logic       fa_carry;

    alu_op_decode u_dec (
        .op  (op),
        .ctl (ctl)
    );

    always_comb begin
        b_eff    = b ^ ctl.inv_b;
        fa_sum   = a ^ b_eff ^ cin;
        fa_carry = (a & b_eff) | (a & cin) | (b_eff & cin);
        out_d.res = 1'b0;
        unique case (ctl.pick)
            PICK_AND:  out_d.res = a & b;
            PICK_OR:   out_d.res = a | b;
            PICK_SUM:  out_d.res = fa_sum;
            PICK_ZERO: out_d.res = 1'b0;
            default:   out_d.res = 1'b0;
        endcase
        out_d.co = ctl.arith ? fa_carry : 1'b0;
    end

    assign res  = out_d.res;
    assign cout = out_d.co;

    always_comb begin
        if (op == OPC_AND)
            AST_SLICE_AND: assert (res == (a & b) && !cout); // R6
        if (op == OPC_OR)
            AST_SLICE_OR: assert (res == (a | b) && !cout); // R6
        if (cout)
            AST_SLICE_CARRY_ARITH: assert (op == OPC_ADD || op == OPC_SUB); // R7
        if (!(op == OPC_AND || op == OPC_OR || op == OPC_ADD || op == OPC_SUB))
            AST_SLICE_UNDEF_QUIET: assert (!res && !cout); // R5
    end

endmodule

// File: rtl/alu_ripple32.sv
module alu_ripple32
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] carry;
    logic [WIDTH-1:0]  res_d;

    // The opcode's top bit starts the chain: 1 for subtract, 0 for add
    assign carry[0] = op[2];

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .op   (op),
            .a    (a[i]),
            .b    (b[i]),
            .cin  (carry[i]),
            .res  (res_d[i]),
            .cout (carry[i+1])
        );
    end

    assign result    = res_d;
    assign carry_out = carry[WIDTH];

    always_comb begin
        if (op == OPC_ADD)
            AST_ADD_WORD: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b})); // R3
        if (op == OPC_SUB)
            AST_SUB_WORD: assert (result == WIDTH'(a - b) && carry_out == (a >= b)); // R4
        if (op == OPC_OR)
            AST_OR_WORD: assert (result == (a | b) && !carry_out); // R2
        if (op == OPC_AND)
            AST_AND_WORD: assert (result == (a & b) && !carry_out); // R1
    end

endmodule

// File: tb/sim_alu_ripple32.sv
module sim_alu_ripple32;

    localparam int W = 32;

    typedef struct {
        bit          is_slice;
        logic [W-1:0] r;
        logic        co;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [2:0]   op = 3'b000;
    logic [W-1:0] a  = '0;
    logic [W-1:0] b  = '0;
    logic [W-1:0] result;
    logic         carry_out;

    logic [2:0] s_op = 3'b000;
    logic       s_a = 1'b0, s_b = 1'b0, s_cin = 1'b0;
    logic       s_res, s_cout;

    alu_ripple32 #(.WIDTH(W)) u0 (
        .op(op), .a(a), .b(b), .result(result), .carry_out(carry_out)
    );

    alu_bit_slice u_slice (
        .op(s_op), .a(s_a), .b(s_b), .cin(s_cin), .res(s_res), .cout(s_cout)
    );

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Monitor: results are compared half a cycle after the inputs change
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.is_slice) begin
                if (s_res !== e.r[0] || s_cout !== e.co) begin
                    fails++;
                    $display("FAIL %s slice op=%b a=%b b=%b cin=%b: got r=%b co=%b exp r=%b co=%b",
                             e.req, s_op, s_a, s_b, s_cin, s_res, s_cout, e.r[0], e.co);
                end
            end else begin
                if (result !== e.r || carry_out !== e.co) begin
                    fails++;
                    $display("FAIL %s op=%b a=%h b=%h: got r=%h co=%b exp r=%h co=%b",
                             e.req, op, a, b, result, carry_out, e.r, e.co);
                end
            end
        end
    end

    task automatic drive_slice(input logic [5:0] n);
        exp_t e;
        logic [2:0] o;
        logic x, y, c, yb;
        @(posedge clk); #1;
        o = n[5:3]; x = n[2]; y = n[1]; c = n[0];
        s_op = o; s_a = x; s_b = y; s_cin = c;
        e.is_slice = 1; e.r = '0; e.co = 1'b0;
        yb = y ^ o[2];
        case (o)
            3'b000: begin e.r[0] = x & y; e.req = "R6"; end
            3'b001: begin e.r[0] = x | y; e.req = "R6"; end
            3'b010, 3'b110: begin
                e.r[0] = x ^ yb ^ c;
                e.co   = (x & yb) | (x & c) | (yb & c);
                e.req  = "R7";
            end
            default: e.req = "R5";
        endcase
        q.push_back(e);
    endtask

    task automatic drive_word(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                              input string req);
        exp_t e;
        logic [W:0] s;
        @(posedge clk); #1;
        op = o; a = x; b = y;
        e.is_slice = 0; e.req = req; e.r = '0; e.co = 1'b0;
        case (o)
            3'b000: e.r = x & y;
            3'b001: e.r = x | y;
            3'b010: begin s = {1'b0, x} + {1'b0, y}; e.r = s[W-1:0]; e.co = s[W]; end
            3'b110: begin e.r = x - y; e.co = (x >= y); end
            default: begin e.r = '0; e.co = 1'b0; end
        endcase
        q.push_back(e);
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Idle state: all-zero inputs give zero outputs (R1)
        drive_word(3'b000, '0, '0, "R1");
        // Exhaustive slice sweep (R5 R6 R7)
        for (int n = 0; n < 64; n++) drive_slice(6'(n));
        // Carry-chain corners (R8, R3, R4)
        drive_word(3'b010, '1, 32'd1, "R8");
        drive_word(3'b010, '1, '1, "R3");
        drive_word(3'b110, '0, 32'd1, "R8");
        drive_word(3'b110, 32'd5, 32'd5, "R4");
        drive_word(3'b110, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
        drive_word(3'b001, 32'hF0F0_0000, 32'h0000_0F0F, "R2");
        drive_word(3'b000, 32'hFFFF_0000, 32'h0FF0_0FF0, "R1");
        drive_word(3'b100, '1, '1, "R5");
        drive_word(3'b111, '1, '1, "R5");
        for (int k = 0; k < 60; k++) begin
            drive_word(3'b000, $urandom, $urandom, "R1");
            drive_word(3'b001, $urandom, $urandom, "R2");
            drive_word(3'b010, $urandom, $urandom, "R3");
            drive_word(3'b110, $urandom, $urandom, "R4");
        end
        for (int k = 0; k < 8; k++) begin
            drive_word(3'b011, $urandom, $urandom, "R5");
            drive_word(3'b100, $urandom, $urandom, "R5");
            drive_word(3'b101, $urandom, $urandom, "R5");
            drive_word(3'b111, $urandom, $urandom, "R5");
        end
        @(posedge clk);
        @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule